// File: doc/BRIEF.md
# Configuration Download Controller

This block fills the configuration memories of a coprocessor while the coprocessor is held off-line, before it starts running. Each target memory word is 64 bits wide. The word arrives as eight bytes on an 8-bit data input. The block collects the bytes and writes the finished word to one of six target memories: four antecedent RAMs, one consequent RAM and one program RAM.

Two load modes exist, and a charge-mode input picks between them. With charge mode low, an external host supplies a byte strobe, the data byte and a 10-bit address that names the target memory and word offset. With charge mode high, the block reads a byte-wide external ROM itself. It drives a 13-bit byte address, made of a 3-bit extension plus the shared 10-bit bus, which now acts as an output. A divided clock of one thirty-second of the master clock paces this read. The ROM read stops after a programmable final byte address, and a done flag then goes high.

Top module: `cfg_download_ctrl`

## Requirements
- R1: While `offline_i` is low, no byte is accepted, the byte-lane state does not advance and `mem_we_o` stays zero.
- R2: With charge mode low, the host address `addr_i[9:7]` selects the memory and `addr_i[6:0]` gives the word offset. Both are sampled together with the eighth byte of the word.
- R3: With charge mode low, `addr_oe_o`, `addr_o` and `ext_addr_o` are all zero. With charge mode high, `addr_oe_o` is 1.
- R4: In self-addressed mode, `div_clk_o` has a period of 32 master cycles and is high for the latter 16 of them. One ROM byte is sampled in the last master cycle of each period.
- R5: In self-addressed mode, the ROM byte address `{ext_addr_o, addr_o}` starts at 0 and rises by one per divided period. Bits [12:10] of this address give the memory select, bits [9:3] give the word offset and bits [2:0] give the byte lane.
- R6: After the byte at address `last_addr_i` has been sampled, `load_done_o` goes high and stays high. The ROM address then holds and no further bytes are taken.
- R7: Bytes are packed least-significant first, so the first byte lands in bits [7:0]. One cycle after the eighth byte is sampled, a one-cycle write strobe appears. That strobe is `mem_we_o[sel]`, where select 0 to 3 are the antecedent RAMs, 4 is the consequent RAM and 5 is the program RAM. `mem_addr_o` and `mem_wdata_o` are valid in the same cycle.
- R8: A word whose select is 6 or 7 produces no write strobe.
- R9: Holding `preset_ni` low for one cycle discards any partly packed word. It also resets the ROM address to 0, clears `load_done_o` and restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_ni | input | 1 | Synchronous restart of loading, active low |
| offline_i | input | 1 | High enables loading |
| charge_mode_i | input | 1 | 0 = host-addressed, 1 = self-addressed ROM read |
| host_wr_i | input | 1 | Host byte strobe (host mode) |
| addr_i | input | 10 | Host address: select [9:7], offset [6:0] |
| data_i | input | 8 | Data byte from host or ROM |
| last_addr_i | input | 13 | Final ROM byte address |
| addr_o | output | 10 | Low ROM address bits (self mode) |
| addr_oe_o | output | 1 | Address bus output enable |
| ext_addr_o | output | 3 | ROM address extension bits [12:10] |
| div_clk_o | output | 1 | Divided load clock |
| mem_we_o | output | 6 | One-hot write strobes per target memory |
| mem_addr_o | output | 7 | Word offset for the write |
| mem_wdata_o | output | 64 | Packed word |
| load_done_o | output | 1 | Self-addressed load finished |

## Verification
The bench targets the following corner cases:
- **Byte-lane counter state.** It sends bytes while off-line, then a full word, and also restarts a word halfway with preset. A counter that advanced while off-line, or that kept stale lanes, would shift the next word or write it early.
- **Illegal selects.** It sends a word with select 6. A decoder that wraps this select would strobe some memory.
- **Memory-select boundary and final address.** The self-addressed run crosses from select 0 into select 1, so the extension bits are used. A wrong bit split, or an off-by-one at the final address, would show up as a wrong word, a missing word or a surplus word.

// File: rtl/cfg_dl_pkg.sv
package cfg_dl_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = 8;
  localparam int unsigned LANE_W    = $clog2(LANES);
  localparam int unsigned WORD_W    = BYTE_W * LANES;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned OFF_W     = 7;
  localparam int unsigned BUS_W     = SEL_W + OFF_W;
  localparam int unsigned ROM_AW    = BUS_W + LANE_W;
  localparam int unsigned EXT_W     = ROM_AW - BUS_W;
  localparam int unsigned NUM_MEM   = 6;
  localparam int unsigned DIV_LOG2  = 5;

  typedef enum logic [SEL_W-1:0] {
    MEM_ANT0 = 3'd0, MEM_ANT1 = 3'd1, MEM_ANT2 = 3'd2, MEM_ANT3 = 3'd3,
    MEM_CONS = 3'd4, MEM_PROG = 3'd5
  } mem_sel_e;
endpackage

// File: rtl/cdl_clk_div.sv
module cdl_clk_div #(
  parameter int unsigned LOG2 = cfg_dl_pkg::DIV_LOG2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o,
  output logic div_clk_o
);
  localparam logic [LOG2-1:0] CNT_MAX = '1;
  localparam logic [LOG2-1:0] HALF    = LOG2'(1) << (LOG2 - 1);

  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o    = run_i && (cnt_q == CNT_MAX);
  assign div_clk_o = cnt_q[LOG2-1];

  // divided clock rises exactly at mid-period
  p_div_mid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_o) |-> (cnt_q == HALF));
  p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cdl_rom_addr_gen.sv
module cdl_rom_addr_gen #(
  parameter int unsigned AW = cfg_dl_pkg::ROM_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [AW-1:0] last_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (addr_q == last_i) done_q <= 1'b1;
      else                  addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  p_rom_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !done_o && !clr_i && addr_o != last_i) |=> (addr_o == $past(addr_o) + 1'b1));
  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (done_o && $stable(addr_o)));
endmodule

// File: rtl/cdl_packer.sv
module cdl_packer #(
  parameter int unsigned BW    = cfg_dl_pkg::BYTE_W,
  parameter int unsigned LANES = cfg_dl_pkg::LANES,
  localparam int unsigned LW   = $clog2(LANES),
  localparam int unsigned WW   = BW * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          host_mode_i,
  input  logic          vld_i,
  input  logic [LW-1:0] lane_i,
  input  logic [BW-1:0] byte_i,
  output logic          commit_o,
  output logic [WW-1:0] word_o
);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

  logic [LW-1:0] hcnt_q;
  logic [LW-1:0] lane;
  logic [BW-1:0] buf_q [LANES];

  assign lane     = host_mode_i ? hcnt_q : lane_i;
  assign commit_o = vld_i && (lane == LAST_LANE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hcnt_q <= '0;
    else if (clr_i)                  hcnt_q <= '0;
    else if (vld_i && host_mode_i)   hcnt_q <= hcnt_q + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          buf_q[g] <= '0;
      else if (vld_i && lane == LW'(g))     buf_q[g] <= byte_i;
    end
    // the closing byte bypasses its buffer
    assign word_o[g*BW +: BW] = (vld_i && lane == LW'(g)) ? byte_i : buf_q[g];
  end

  p_lane_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(hcnt_q));
endmodule

// File: rtl/cdl_write_port.sv
module cdl_write_port #(
  parameter int unsigned WW      = cfg_dl_pkg::WORD_W,
  parameter int unsigned SW      = cfg_dl_pkg::SEL_W,
  parameter int unsigned OW      = cfg_dl_pkg::OFF_W,
  parameter int unsigned NUM_MEM = cfg_dl_pkg::NUM_MEM
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               commit_i,
  input  logic [SW-1:0]      sel_i,
  input  logic [OW-1:0]      off_i,
  input  logic [WW-1:0]      word_i,
  output logic [NUM_MEM-1:0] we_o,
  output logic [OW-1:0]      addr_o,
  output logic [WW-1:0]      wdata_o
);
  logic [NUM_MEM-1:0] hit;
  logic [NUM_MEM-1:0] we_q;
  logic [OW-1:0]      addr_q;
  logic [WW-1:0]      data_q;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_dec
    assign hit[m] = commit_i && (sel_i == SW'(m));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= clr_i ? '0 : hit;
      if (commit_i && !clr_i) begin
        addr_q <= off_i;
        data_q <= word_i;
      end
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = data_q;

  p_we_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  p_we_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |=> ($past(commit_i) == 1'b0 || we_o == '0 || $countones(we_o) == 1));
  p_bad_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && int'(sel_i) >= NUM_MEM) |=> (we_o == '0));
endmodule

// File: rtl/cfg_download_ctrl.sv
module cfg_download_ctrl
  import cfg_dl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                preset_ni,
  input  logic                offline_i,
  input  logic                charge_mode_i,
  input  logic                host_wr_i,
  input  logic [BUS_W-1:0]    addr_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic [ROM_AW-1:0]   last_addr_i,
  output logic [BUS_W-1:0]    addr_o,
  output logic                addr_oe_o,
  output logic [EXT_W-1:0]    ext_addr_o,
  output logic                div_clk_o,
  output logic [NUM_MEM-1:0]  mem_we_o,
  output logic [OFF_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic                load_done_o
);
  logic              clr;
  logic              self_run;
  logic              tick;
  logic              done;
  logic [ROM_AW-1:0] rom_addr;
  logic              byte_vld;
  logic              commit;
  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  sel;
  logic [OFF_W-1:0]  off;

  assign clr      = !preset_ni;
  assign self_run = offline_i && charge_mode_i && !done && preset_ni;
  assign byte_vld = charge_mode_i ? tick
                                  : (offline_i && host_wr_i && preset_ni);

  // rom byte address layout: {sel, off, lane}
  assign sel = charge_mode_i ? rom_addr[ROM_AW-1 -: SEL_W] : addr_i[BUS_W-1 -: SEL_W];
  assign off = charge_mode_i ? rom_addr[LANE_W +: OFF_W]   : addr_i[OFF_W-1:0];

  cdl_clk_div #(.LOG2(DIV_LOG2)) u_div (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(self_run),
    .tick_o(tick), .div_clk_o
  );

  cdl_rom_addr_gen #(.AW(ROM_AW)) u_agen (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick),
    .last_i(last_addr_i), .addr_o(rom_addr), .done_o(done)
  );

  cdl_packer #(.BW(BYTE_W), .LANES(LANES)) u_pack (
    .clk_i, .rst_ni, .clr_i(clr), .host_mode_i(!charge_mode_i),
    .vld_i(byte_vld), .lane_i(rom_addr[LANE_W-1:0]), .byte_i(data_i),
    .commit_o(commit), .word_o(word)
  );

  cdl_write_port #(.WW(WORD_W), .SW(SEL_W), .OW(OFF_W), .NUM_MEM(NUM_MEM)) u_wr (
    .clk_i, .rst_ni, .clr_i(clr), .commit_i(commit), .sel_i(sel), .off_i(off),
    .word_i(word), .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o)
  );

  assign addr_oe_o   = charge_mode_i;
  assign addr_o      = charge_mode_i ? rom_addr[BUS_W-1:0] : '0;
  assign ext_addr_o  = charge_mode_i ? rom_addr[ROM_AW-1 -: EXT_W] : '0;
  assign load_done_o = done;

  p_offline_block_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!offline_i && !charge_mode_i) |=> (mem_we_o == '0));
  p_bus_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !charge_mode_i |-> (ext_addr_o == '0 && addr_o == '0 && !addr_oe_o));
  p_preset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_ni |=> (!load_done_o && mem_we_o == '0));
endmodule

// File: tb/cfg_download_ctrl_tb_top.sv
module cfg_download_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        preset_n = 1'b1;
  logic        offline = 1'b0;
  logic        charge = 1'b0;
  logic        host_wr = 1'b0;
  logic [9:0]  haddr = '0;
  logic [7:0]  hdata = '0;
  logic [12:0] last_addr = '0;
  logic [7:0]  data;
  logic [9:0]  addr_o;
  logic        addr_oe;
  logic [2:0]  ext_addr;
  logic        div_clk;
  logic [5:0]  we;
  logic [6:0]  maddr;
  logic [63:0] wdata;
  logic        done;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int wr_count = 0;
  int self_widx = 0;
  logic self_chk = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [12:0] a);
    return 8'((a * 37) + (a >> 5) + 13'h5A);
  endfunction

  function automatic logic [63:0] rom_word(input int idx);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = rom_fn(13'(idx * 8 + k));
    return w;
  endfunction

  assign data = charge ? rom_fn({ext_addr, addr_o}) : hdata;

  cfg_download_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .preset_ni(preset_n), .offline_i(offline),
    .charge_mode_i(charge), .host_wr_i(host_wr), .addr_i(haddr), .data_i(data),
    .last_addr_i(last_addr), .addr_o(addr_o), .addr_oe_o(addr_oe),
    .ext_addr_o(ext_addr), .div_clk_o(div_clk), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .load_done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // negedge monitor: counts strobes, checks self-addressed words (R5 R7)
  always @(negedge clk) begin
    if (|we) begin
      wr_count++;
      if (self_chk) begin
        mon_checks++;
        if (we != 6'(1 << (self_widx >> 7)) || maddr != 7'(self_widx) ||
            wdata != rom_word(self_widx)) begin
          mon_fails++;
          $display("FAIL R5/R7 self word %0d actual=%h/%h/%h expected=%h/%h/%h",
                   self_widx, we, maddr, wdata, 6'(1 << (self_widx >> 7)),
                   7'(self_widx), rom_word(self_widx));
        end
        self_widx++;
      end
    end
  end

  // send 8 bytes; returns strobe state in the cycle after the last byte
  task automatic send_word(input logic [2:0] sel, input logic [6:0] off,
                           input logic [63:0] w, output logic [5:0] we_s,
                           output logic [6:0] a_s, output logic [63:0] d_s);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      host_wr = 1'b1;
      hdata   = w[k*8 +: 8];
      haddr   = (k == 7) ? {sel, off} : 10'(k * 91);
    end
    @(negedge clk);
    host_wr = 1'b0;
    we_s = we; a_s = maddr; d_s = wdata;
  endtask

  task automatic host_ok(input logic [2:0] sel, input logic [6:0] off,
                         input logic [63:0] w, input string req);
    logic [5:0] ws; logic [6:0] as; logic [63:0] ds;
    send_word(sel, off, w, ws, as, ds);
    check(ws == 6'(1 << sel), {req, " strobe"}, 64'(ws), 64'(1 << sel));
    check(as == off, {req, " offset"}, 64'(as), 64'(off));
    check(ds == w, {req, " data"}, ds, w);
    @(negedge clk);
    check(we == '0, {req, " single pulse"}, 64'(we), 0);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    logic [5:0] ws; logic [6:0] as; logic [63:0] ds;
    int wc0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R3
    check(we == 0 && done == 0 && addr_oe == 0, "R3 reset state", {we, done, addr_oe}, 0);
    check(ext_addr == 0 && addr_o == 0, "R3 bus idle host mode", {ext_addr, addr_o}, 0);

    // R1: bytes while off-line are dropped
    wc0 = wr_count;
    send_word(3'd1, 7'd9, 64'h0102_0304_0506_0708, ws, as, ds);
    check(ws == 0 && wr_count == wc0, "R1 no write off-line", 64'(ws), 0);
    offline = 1'b1;
    // lane counter untouched: fresh word packs from lane 0
    host_ok(3'd2, 7'd77, 64'hA1B2_C3D4_E5F6_0718, "R1 R7 lane intact");

    // R2 R7 directed: every legal select, extreme offsets
    host_ok(3'd0, 7'd0,   64'h0000_0000_0000_00FF, "R2 R7 ant0 low first");
    host_ok(3'd3, 7'd127, 64'hFF00_0000_0000_0000, "R2 ant3 top offset");
    host_ok(3'd4, 7'd5,   64'h1122_3344_5566_7788, "R2 R7 consequent");
    host_ok(3'd5, 7'd64,  64'h8877_6655_4433_2211, "R2 R7 program");

    // R8: illegal select produces no strobe
    wc0 = wr_count;
    send_word(3'd6, 7'd1, 64'hDEAD_BEEF_0BAD_F00D, ws, as, ds);
    check(ws == 0, "R8 select 6 ignored", 64'(ws), 0);
    send_word(3'd7, 7'd2, 64'hCAFE_0000_1111_2222, ws, as, ds);
    check(ws == 0 && wr_count == wc0, "R8 select 7 ignored", 64'(ws), 0);
    host_ok(3'd1, 7'd3, 64'h0F0E_0D0C_0B0A_0908, "R8 next word aligned");

    // R9: preset in mid-word discards partial bytes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); host_wr = 1'b1; hdata = 8'hEE;
    end
    @(negedge clk); host_wr = 1'b0; preset_n = 1'b0;
    @(negedge clk); preset_n = 1'b1;
    host_ok(3'd2, 7'd11, 64'h7766_5544_3322_1100, "R9 preset realigns");

    // random host words, R2 R7
    for (int i = 0; i < 24; i++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      host_ok(3'($urandom_range(0, 5)), 7'($urandom()), w, "R2 R7 random");
    end

    // self-addressed mode
    charge = 1'b1;
    last_addr = 13'd1039;
    preset_n = 1'b0;
    @(negedge clk); preset_n = 1'b1;
    check(addr_oe == 1, "R3 oe in self mode", 64'(addr_oe), 1);
    check({ext_addr, addr_o} == 0, "R5 start address", 64'({ext_addr, addr_o}), 0);
    // R4: measure divided period and high time
    begin
      int per, hi;
      while (div_clk != 0) @(negedge clk);
      while (div_clk != 1) @(negedge clk);
      per = 0; hi = 0;
      do begin
        if (div_clk) hi++;
        per++;
        @(negedge clk);
      end while (!(div_clk == 1 && per > 16 && hi == 16 && per >= 32) && per < 40);
      check(per == 32, "R4 divided period", 64'(per), 32);
      check(hi == 16, "R4 divided high time", 64'(hi), 16);
    end
    // R5: address has advanced by one per period; after 1.x periods addr is 1
    check({ext_addr, addr_o} == 13'd1, "R5 address step", 64'({ext_addr, addr_o}), 1);
    repeat (100) @(negedge clk);
    // R9: restart self load
    preset_n = 1'b0;
    @(negedge clk); preset_n = 1'b1;
    check({ext_addr, addr_o} == 0, "R9 self restart address", 64'({ext_addr, addr_o}), 0);
    self_widx = 0;
    self_chk  = 1'b1;
    // R4 sampling point: byte 0 is taken at the 32nd edge, address becomes 1
    repeat (31) @(negedge clk);
    check({ext_addr, addr_o} == 0, "R4 address held full period", 64'({ext_addr, addr_o}), 0);
    @(negedge clk);
    check({ext_addr, addr_o} == 1, "R4 address after period", 64'({ext_addr, addr_o}), 1);
    begin
      int guard = 0;
      while (!done && guard < 40000) begin @(negedge clk); guard++; end
    end
    repeat (2) @(negedge clk);
    self_chk = 1'b0;
    check(done == 1, "R6 done raised", 64'(done), 1);
    check(self_widx == 130, "R6 R5 word count", 64'(self_widx), 130);
    check({ext_addr, addr_o} == 13'd1039, "R6 final address", 64'({ext_addr, addr_o}), 1039);
    wc0 = wr_count;
    repeat (100) @(negedge clk);
    check(wr_count == wc0 && {ext_addr, addr_o} == 13'd1039 && done,
          "R6 stopped after final", 64'(wr_count - wc0), 0);
    preset_n = 1'b0;
    @(negedge clk); preset_n = 1'b1;
    check(done == 0 && {ext_addr, addr_o} == 0, "R9 done cleared", {done, ext_addr, addr_o}, 0);
    // R1 in self mode: off-line low freezes the read
    offline = 1'b0;
    repeat (80) @(negedge clk);
    check({ext_addr, addr_o} == 0, "R1 self mode frozen", 64'({ext_addr, addr_o}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule